// File: doc/BRIEF.md
# Sector Write-Protection Guard

This block decides whether a program or erase to a flash address may go ahead. The array is split into 64 sectors of 64 KB each. Each sector has two state bits. The protect bit can be set and cleared by commands. The lockdown bit, once set, stays set until reset. A sector-scoped program or erase is permitted only when both bits of the target sector are clear. A whole-chip erase is permitted only when no sector in the array is protected or locked down.

Protection changes arrive as single-cycle requests: protect one sector, unprotect one sector, protect every sector, unprotect every sector, or lock down one sector. An active-low write-protect input freezes all protect bits while it is low. Protect-type requests made during that time are dropped, and the guard flags each one as rejected. Lockdown requests are still taken while the pin is low, because they only tighten protection. Reset sets every protect bit and clears every lockdown bit. The permit output is combinational from the registered state and the query inputs, so any change made by a request is seen from the cycle after that request.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector is protected and none is locked down, so every sector query and the chip query return deny (chk_permit = 0).
- R2: The sector index is address bits [21:16]. Bits [23:22] and [15:0] have no effect on which sector a request or query selects.
- R3: With wr_prot_n high, req_op = 1 sets the protect bit of the addressed sector and req_op = 2 clears it. No other sector changes, and the effect is visible from the next cycle.
- R4: With wr_prot_n high, req_op = 3 sets every protect bit and req_op = 4 clears every protect bit. Neither touches the lockdown bits.
- R5: While wr_prot_n is low, a valid request with req_op 1 to 4 changes no state, and req_reject is high in the following cycle. req_reject is low after any other cycle.
- R6: req_op = 5 sets the lockdown bit of the addressed sector whatever the level of wr_prot_n. No request clears a lockdown bit; only reset does.
- R7: A sector query (chk_chip = 0) gives chk_permit = 1 exactly when the selected sector has neither its protect bit nor its lockdown bit set.
- R8: A chip query (chk_chip = 1) gives chk_permit = 1 exactly when no sector has its protect bit or its lockdown bit set.
- R9: A request with req_valid low, or with req_op 0, 6 or 7, changes no state and does not raise req_reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset that loads the default state |
| wr_prot_n | input | 1 | Active-low hardware lock of the protect bits; tie high when unused |
| req_valid | input | 1 | A protection request is present this cycle |
| req_op | input | 3 | Request code: 1 protect sector, 2 unprotect sector, 3 protect all, 4 unprotect all, 5 lock down sector |
| req_addr | input | 24 | Address that selects the sector for requests 1, 2 and 5 |
| req_reject | output | 1 | High for one cycle after a protect-type request that was dropped because the hardware lock was active |
| chk_addr | input | 24 | Target address of the queried program or erase |
| chk_chip | input | 1 | High to query a whole-chip erase instead of one sector |
| chk_permit | output | 1 | High when the queried operation is allowed |

## Verification
Assertions check several relations on every cycle:
- A locked-down sector is never permitted.
- A chip query is never permitted while any protect or lockdown bit is set.
- Lockdown bits never fall.
- Protect bits hold still across a request made while the hardware lock is active.
- A global protect leaves every protect bit set.
- A rejected request is followed by req_reject.

Only the bench's scenarios can show the rest:
- The address bits outside [21:16] are ignored.
- A single-sector command leaves its neighbours untouched.
- Lockdown survives a later global unprotect.
- Unused op codes are ignored.

The bench shows these by sweeping queries over all 64 sectors after each phase.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_SECT_PROT = 3'd1,
    OP_SECT_OPEN = 3'd2,
    OP_ALL_PROT  = 3'd3,
    OP_ALL_OPEN  = 3'd4,
    OP_LOCK      = 3'd5
  } sg_op_e;

  function automatic logic is_prot_op(input logic [2:0] op);
    return (op >= 3'd1) && (op <= 3'd4);
  endfunction
endpackage

// File: rtl/sg_ctrl.sv
module sg_ctrl #(
  parameter int SECT_W = 6,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prot_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [SECT_W-1:0] req_sec,
  output logic [NSECT-1:0]  set_prot,
  output logic [NSECT-1:0]  clr_prot,
  output logic [NSECT-1:0]  set_lock,
  output logic              frozen_req,
  output logic              reject_q
);
  import sg_pkg::*;

  logic [NSECT-1:0] sel;
  assign sel = {{(NSECT-1){1'b0}}, 1'b1} << req_sec;

  assign frozen_req = req_valid && !wr_prot_n && is_prot_op(req_op);

  always_comb begin
    set_prot = '0;
    clr_prot = '0;
    set_lock = '0;
    if (req_valid) begin
      unique case (req_op)
        OP_SECT_PROT: if (wr_prot_n) set_prot = sel;
        OP_SECT_OPEN: if (wr_prot_n) clr_prot = sel;
        OP_ALL_PROT:  if (wr_prot_n) set_prot = '1;
        OP_ALL_OPEN:  if (wr_prot_n) clr_prot = '1;
        OP_LOCK:      set_lock = sel;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reject_q <= 1'b0;
    else        reject_q <= frozen_req;
  end

  a_r5_reject_follows: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_req |=> reject_q);
  a_r9_no_spurious_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || !is_prot_op(req_op)) |=> !reject_q);
endmodule

// File: rtl/sg_bank.sv
module sg_bank #(
  parameter int NSECT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSECT-1:0] set_prot,
  input  logic [NSECT-1:0] clr_prot,
  input  logic [NSECT-1:0] set_lock,
  output logic [NSECT-1:0] prot_vec,
  output logic [NSECT-1:0] lock_vec
);
  for (genvar i = 0; i < NSECT; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prot_vec[i] <= 1'b1;
        lock_vec[i] <= 1'b0;
      end else begin
        if (set_prot[i])      prot_vec[i] <= 1'b1;
        else if (clr_prot[i]) prot_vec[i] <= 1'b0;
        if (set_lock[i])      lock_vec[i] <= 1'b1;
      end
    end
  end

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    &(~$past(lock_vec) | lock_vec));
endmodule

// File: rtl/sg_judge.sv
module sg_judge #(
  parameter int SECT_W = 6,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic [NSECT-1:0]  prot_vec,
  input  logic [NSECT-1:0]  lock_vec,
  input  logic [SECT_W-1:0] chk_sec,
  input  logic              chk_chip,
  output logic              permit
);
  function automatic logic chip_clear(input logic [NSECT-1:0] p,
                                      input logic [NSECT-1:0] l);
    return ~|(p | l);
  endfunction

  assign permit = chk_chip ? chip_clear(prot_vec, lock_vec)
                           : !(prot_vec[chk_sec] || lock_vec[chk_sec]);
endmodule

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W   = 24,
  parameter int SECT_LSB = 16,
  parameter int SECT_W   = 6,
  localparam int NSECT   = 1 << SECT_W,
  localparam int SECT_HI = SECT_LSB + SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_prot_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_reject,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_chip,
  output logic              chk_permit
);
  import sg_pkg::*;

  function automatic logic [SECT_W-1:0] sect_of(input logic [ADDR_W-1:0] a);
    return a[SECT_LSB +: SECT_W];
  endfunction

  logic [SECT_W-1:0] req_sec, chk_sec;
  logic [NSECT-1:0]  set_prot, clr_prot, set_lock, prot_vec, lock_vec;
  logic              frozen_req;
  logic              unused_addr_bits;

  assign req_sec = sect_of(req_addr);
  assign chk_sec = sect_of(chk_addr);
  assign unused_addr_bits = ^{req_addr[ADDR_W-1:SECT_HI], req_addr[SECT_LSB-1:0],
                              chk_addr[ADDR_W-1:SECT_HI], chk_addr[SECT_LSB-1:0]};

  sg_ctrl #(.SECT_W(SECT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_prot_n(wr_prot_n), .req_valid(req_valid),
    .req_op(req_op), .req_sec(req_sec), .set_prot(set_prot),
    .clr_prot(clr_prot), .set_lock(set_lock), .frozen_req(frozen_req),
    .reject_q(req_reject)
  );

  sg_bank #(.NSECT(NSECT)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_prot(set_prot), .clr_prot(clr_prot),
    .set_lock(set_lock), .prot_vec(prot_vec), .lock_vec(lock_vec)
  );

  sg_judge #(.SECT_W(SECT_W)) u_judge (
    .prot_vec(prot_vec), .lock_vec(lock_vec), .chk_sec(chk_sec),
    .chk_chip(chk_chip), .permit(chk_permit)
  );

  a_r5_wp_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    frozen_req |=> $stable(prot_vec));
  a_r4_global_prot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wr_prot_n && req_op == OP_ALL_PROT) |=> &prot_vec);
  a_r6_lock_denies: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_chip && lock_vec[chk_sec]) |-> !chk_permit);
  a_r8_chip_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_chip && (|prot_vec || |lock_vec)) |-> !chk_permit);
endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_prot_n = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [23:0] req_addr = '0;
  logic        req_reject;
  logic [23:0] chk_addr = '0;
  logic        chk_chip = 1'b0;
  logic        chk_permit;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  bit m_prot[64];
  bit m_lock[64];
  bit m_reject;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wr_prot_n(wr_prot_n), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_reject(req_reject),
    .chk_addr(chk_addr), .chk_chip(chk_chip), .chk_permit(chk_permit)
  );

  function automatic int sec_idx(input logic [23:0] a);
    return (int'(a) / 65536) % 64;
  endfunction

  function automatic bit model_permit();
    if (chk_chip) begin
      for (int i = 0; i < 64; i++) if (m_prot[i] || m_lock[i]) return 0;
      return 1;
    end
    return !(m_prot[sec_idx(chk_addr)] || m_lock[sec_idx(chk_addr)]);
  endfunction

  task automatic model_clock();
    int s;
    s = sec_idx(req_addr);
    m_reject = 0;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin m_prot[i] = 1; m_lock[i] = 0; end
    end else if (req_valid) begin
      if (req_op >= 1 && req_op <= 4 && !wr_prot_n) m_reject = 1;
      else case (req_op)
        3'd1: m_prot[s] = 1;
        3'd2: m_prot[s] = 0;
        3'd3: for (int i = 0; i < 64; i++) m_prot[i] = 1;
        3'd4: for (int i = 0; i < 64; i++) m_prot[i] = 0;
        3'd5: m_lock[s] = 1;
        default: ;
      endcase
    end
  endtask

  // inputs are already set after a negedge; clock once, compare at next negedge
  task automatic step(input string tag);
    @(posedge clk);
    model_clock();
    @(negedge clk);
    vectors++;
    if (chk_permit !== model_permit()) begin
      miscompares++;
      $display("FAIL %s permit: actual %b expected %b (chip=%b addr=%h)",
               tag, chk_permit, model_permit(), chk_chip, chk_addr);
    end
    vectors++;
    if (req_reject !== m_reject) begin
      miscompares++;
      $display("FAIL R5 reject: actual %b expected %b", req_reject, m_reject);
    end
  endtask

  task automatic request(input logic [2:0] op, input logic [23:0] a, input string tag);
    req_valid = 1'b1; req_op = op; req_addr = a;
    step(tag);
    req_valid = 1'b0; req_op = 3'd0;
    step(tag);
  endtask

  // query every sector with junk in the ignored address bits (R2), then the chip
  task automatic sweep(input string tag);
    for (int s = 0; s < 64; s++) begin
      chk_chip = 1'b0;
      chk_addr = {2'(s % 4), 6'(s), 16'(s * 977)};
      step(tag);
    end
    chk_chip = 1'b1;
    step("R8");
    chk_chip = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step("R1");
    step("R1");
    rst_n = 1'b1;
    sweep("R1");
    // R2 R3: unprotect sector 5 via an aliased address
    request(3'd2, {2'b11, 6'd5, 16'hABCD}, "R3");
    sweep("R3");
    request(3'd2, {2'b00, 6'd63, 16'h0000}, "R3");
    sweep("R7");
    // R4: global unprotect, chip then allowed (R8)
    request(3'd4, 24'h0, "R4");
    sweep("R8");
    request(3'd1, {2'b01, 6'd10, 16'hFFFF}, "R3");
    sweep("R8");
    // R5: hardware lock freezes protect bits
    wr_prot_n = 1'b0;
    request(3'd3, 24'h0, "R5");
    request(3'd2, {2'b00, 6'd10, 16'h0}, "R5");
    request(3'd1, {2'b00, 6'd7, 16'h0}, "R5");
    request(3'd4, 24'h0, "R5");
    sweep("R5");
    // R6: lockdown accepted under hardware lock, survives unprotect
    request(3'd5, {2'b10, 6'd20, 16'h1234}, "R6");
    wr_prot_n = 1'b1;
    request(3'd4, 24'h0, "R6");
    request(3'd2, {2'b00, 6'd20, 16'h0}, "R6");
    sweep("R6");
    // R9: ignored codes and valid low
    request(3'd6, {2'b00, 6'd30, 16'h0}, "R9");
    request(3'd7, {2'b00, 6'd31, 16'h0}, "R9");
    req_op = 3'd3; req_valid = 1'b0;
    step("R9");
    req_op = 3'd0;
    sweep("R9");
    // R4: global protect; R6 lock still present
    request(3'd3, 24'h0, "R4");
    request(3'd5, {2'b00, 6'd0, 16'h0}, "R6");
    sweep("R4");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule